// File: doc/BRIEF.md
# Buffered Pulse-Width Wave Generator

The block is an 8-bit timer that produces a square wave with independently programmable period and high/low split. A counter counts up on a selected tick strobe. On each tick the value it is about to take is compared with two registers: a period limit and a toggle point. Each compare hit can invert the output flop, and each raises its own one-cycle event pulse. When the counter reaches the period limit it returns to zero on the following tick, so one full cycle of the wave lasts the period value plus one ticks.

Software reaches three registers through a one-cycle write strobe. The toggle point can be staged in a shadow register. When staging is on, a new value written in the middle of a cycle takes effect only at the next period hit, so the current cycle is never cut short. The prescaler chain is outside the block. Its three taps (every base tick, every fourth, every sixteenth) arrive as single-cycle strobes, and a 2-bit select chooses one of them.

Top module: `dbuf_ppg`

## Requirements
- R1: After reset, `wave_out`, `duty_irq` and `period_irq` are 0. The toggle register is 0, the period register is 255 and the control register is 0.
- R2: While `run_a` and `run_b` are both 1, the counter advances by one on each strobe chosen by `tick_sel`: 00 selects `tick_d1`, 01 selects `tick_d4`, 10 selects `tick_d16`, and 11 selects no strobe, so the counter stops.
- R3: A tick that brings the counter to the period value raises `period_irq` for one cycle in the next clock, and the tick after it returns the counter to 0. Consecutive `period_irq` pulses are therefore (period+1) selected ticks apart.
- R4: A tick that brings the counter to the toggle value raises `duty_irq` for one cycle in the next clock.
- R5: Control bit 1 (toggle enable) makes `wave_out` invert on every toggle hit and every period hit. When the bit is 0, `wave_out` keeps its level while the events continue.
- R6: When control bit 0 (staging) is 1, a write to address 0 goes only to the shadow register. The shadow value becomes the active toggle value at the next period hit.
- R7: When staging is off, a write to address 0 changes the active toggle value from the next cycle, including in the middle of a cycle.
- R8: While `run_a` or `run_b` is 0, the counter is held at 0, no event pulses occur and `wave_out` keeps its level.
- R9: A write to address 2 with bit 2 set loads bit 3 into `wave_out` at the next clock. This takes priority over a toggle in the same cycle.
- R10: The register addresses are 0 for the toggle value, 1 for the period value and 2 for control. A control write replaces bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_d1 | input | 1 | Base tick strobe |
| tick_d4 | input | 1 | Tick strobe at one quarter of the base rate |
| tick_d16 | input | 1 | Tick strobe at one sixteenth of the base rate |
| tick_sel | input | 2 | Tick source select |
| run_a | input | 1 | Run enable, first bit |
| run_b | input | 1 | Run enable, second (paired) bit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| duty_irq | output | 1 | Toggle-point hit pulse |
| period_irq | output | 1 | Period hit pulse |
| wave_out | output | 1 | Generated waveform |

## Verification
The assertions assume that software keeps the period value at 1 or more and keeps the toggle value strictly below it, so the two hits never coincide and a period hit is never followed at once by another. The stimulus meets this by loading the period and toggle registers only while a run bit is low, or by writing toggle values that stay below the programmed period. It changes the tick select only while the counter is below the period, so no stray wrap past 255 occurs. A behavioural model in the bench tracks the counter, both registers and the flop, and is compared with the outputs on every clock. Directed measurements of pulse spacing cover each tick source, and a timed mid-cycle write checks when a staged or unstaged toggle value takes effect.

// File: rtl/dbuf_ppg.sv
module dbuf_ppg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_d1,
  input  logic         tick_d4,
  input  logic         tick_d16,
  input  logic [1:0]   tick_sel,
  input  logic         run_a,
  input  logic         run_b,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         duty_irq,
  output logic         period_irq,
  output logic         wave_out
);
  localparam logic [1:0] A_DUTY = 2'd0;
  localparam logic [1:0] A_PER  = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  logic [W-1:0] cnt, duty_r, duty_buf, period_r, cnt_nxt;
  logic         stage_en, inv_en, tick_v;

  always_comb begin
    case (tick_sel)
      2'b00:   tick_v = tick_d1;
      2'b01:   tick_v = tick_d4;
      2'b10:   tick_v = tick_d16;
      default: tick_v = 1'b0;
    endcase
  end

  wire running  = run_a & run_b;
  wire step     = running & tick_v;
  assign cnt_nxt = (cnt == period_r) ? '0 : cnt + 1'b1;
  wire hit_duty = step && (cnt_nxt == duty_r);
  wire hit_per  = step && (cnt_nxt == period_r);
  wire wr_duty  = wr_en && (wr_addr == A_DUTY);
  wire wr_per   = wr_en && (wr_addr == A_PER);
  wire wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  wire force_ff = wr_ctrl && wr_data[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      duty_r     <= '0;
      duty_buf   <= '0;
      period_r   <= '1;
      stage_en   <= 1'b0;
      inv_en     <= 1'b0;
      wave_out   <= 1'b0;
      duty_irq   <= 1'b0;
      period_irq <= 1'b0;
    end else begin
      cnt        <= !running ? '0 : (step ? cnt_nxt : cnt);
      duty_irq   <= hit_duty;
      period_irq <= hit_per;
      if (force_ff)                       wave_out <= wr_data[3];
      else if (inv_en && (hit_duty || hit_per)) wave_out <= ~wave_out;
      if (wr_duty) begin
        duty_buf <= wr_data;
        if (!stage_en) duty_r <= wr_data;
      end
      if (stage_en && hit_per) duty_r <= duty_buf;
      if (wr_per)  period_r <= wr_data;
      if (wr_ctrl) {inv_en, stage_en} <= wr_data[1:0];
    end
  end

  p_wrap_after_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == period_r) |=> (cnt == '0));
  p_period_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (period_irq && period_r != '0) |=> !period_irq);
  p_quiet_when_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (!duty_irq && !period_irq && cnt == '0));
  p_wave_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv_en && !force_ff) |=> $stable(wave_out));
  p_staged_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_en && !hit_per) |=> $stable(duty_r));
  p_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    force_ff |=> (wave_out == $past(wr_data[3])));
endmodule

// File: tb/dbuf_ppg_tb.sv
module dbuf_ppg_tb;
  logic clk = 0, rst_n = 0;
  logic tick_d1 = 0, tick_d4 = 0, tick_d16 = 0;
  logic [1:0] tick_sel = 0;
  logic run_a = 0, run_b = 0, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic duty_irq, period_irq, wave_out;
  int total = 0, bad = 0, bc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbuf_ppg u_dut (.clk, .rst_n, .tick_d1, .tick_d4, .tick_d16, .tick_sel,
    .run_a, .run_b, .wr_en, .wr_addr, .wr_data, .duty_irq, .period_irq, .wave_out);

  always @(negedge clk) begin
    bc++;
    tick_d1  = (bc % 2 == 0);
    tick_d4  = (bc % 8 == 0);
    tick_d16 = (bc % 32 == 0);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference
  int m_cnt = 0, m_duty = 0, m_buf = 0, m_per = 255;
  bit m_stage = 0, m_inv = 0, m_wave = 0, m_di = 0, m_pi = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_duty = 0; m_buf = 0; m_per = 255;
      m_stage = 0; m_inv = 0; m_wave = 0; m_di = 0; m_pi = 0;
    end else begin
      bit tk, pm;
      int n, old_buf;
      bit old_stage, nw;
      tk = (tick_sel == 0) ? tick_d1 : (tick_sel == 1) ? tick_d4 :
           (tick_sel == 2) ? tick_d16 : 1'b0;
      m_di = 0; m_pi = 0; pm = 0; nw = m_wave;
      old_buf = m_buf; old_stage = m_stage;
      if (!(run_a && run_b)) m_cnt = 0;
      else if (tk) begin
        n = (m_cnt == m_per) ? 0 : (m_cnt + 1) % 256;
        m_di = (n == m_duty);
        pm = (n == m_per);
        m_pi = pm;
        m_cnt = n;
        if (m_inv && (m_di || m_pi)) nw = !nw;
      end
      if (wr_en && wr_addr == 2 && wr_data[2]) nw = wr_data[3];
      m_wave = nw;
      if (wr_en && wr_addr == 0) begin
        m_buf = wr_data;
        if (!old_stage) m_duty = wr_data;
      end
      if (old_stage && pm) m_duty = old_buf;
      if (wr_en && wr_addr == 1) m_per = wr_data;
      if (wr_en && wr_addr == 2) begin m_stage = wr_data[0]; m_inv = wr_data[1]; end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    check(wave_out == m_wave, "R5/R9 model wave", wave_out, m_wave);
    check(duty_irq == m_di, "R4/R6/R7 model duty_irq", duty_irq, m_di);
    check(period_irq == m_pi, "R2/R3/R8 model period_irq", period_irq, m_pi);
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_pi();
    for (int k = 0; k < 20000 && !period_irq; k++) @(negedge clk);
  endtask

  task automatic gap(output int n);
    wait_pi();
    n = 0;
    do begin @(negedge clk); n++; end while (!period_irq && n < 20000);
  endtask

  task automatic duties_before_period(output int c);
    c = 0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (duty_irq) c++;
      if (period_irq) break;
    end
  endtask

  task automatic cycles_to_duty(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!duty_irq && n < 20000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, c;
    bit w;
    repeat (3) @(negedge clk);
    check(wave_out == 0 && duty_irq == 0 && period_irq == 0, "R1 reset outputs",
          {wave_out, duty_irq, period_irq}, 0);
    rst_n = 1;
    // R10: setup writes at addresses 0,1,2
    wr(2, 8'h02); wr(1, 5); wr(0, 2);
    tick_sel = 0; run_a = 1; run_b = 1;
    gap(n); gap(n);
    check(n == 12, "R3 period spacing tick_d1", n, 12);
    wait_pi(); @(negedge clk); cycles_to_duty(n);
    check(n == 5, "R4 duty after period", n, 5);
    tick_sel = 1; gap(n); gap(n);
    check(n == 48, "R2 spacing tick_d4", n, 48);
    tick_sel = 2; gap(n); gap(n);
    check(n == 192, "R2 spacing tick_d16", n, 192);
    tick_sel = 3; c = 0;
    for (int k = 0; k < 300; k++) begin @(negedge clk); c += period_irq + duty_irq; end
    check(c == 0, "R2 select 11 stops", c, 0);
    tick_sel = 0; wr(2, 8'h00); w = wave_out; c = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); c += period_irq; if (wave_out != w) c = -1000; end
    check(c > 0, "R5 hold with toggle off", c, 1);
    wr(2, 8'h0C);
    check(wave_out == 1, "R9 force high", wave_out, 1);
    wr(2, 8'h06);
    check(wave_out == 0, "R9 force low", wave_out, 0);
    run_b = 0; w = wave_out; c = 0;
    for (int k = 0; k < 100; k++) begin @(negedge clk); c += period_irq + duty_irq + (wave_out != w); end
    check(c == 0, "R8 stopped quiet", c, 0);
    // R6 staged mid-cycle write
    run_a = 0; run_b = 1;
    wr(2, 8'h02); wr(0, 10); wr(1, 40); wr(2, 8'h03);
    run_a = 1;
    cycles_to_duty(n); repeat (10) @(negedge clk);
    wr(0, 30);
    duties_before_period(c);
    check(c == 0, "R6 staged value not used early", c, 0);
    cycles_to_duty(n);
    check(n == 62, "R6 staged value after period", n, 62);
    // R7 direct write
    wr(2, 8'h02); wr(0, 10);
    wait_pi(); cycles_to_duty(n); repeat (10) @(negedge clk);
    wr(0, 30);
    duties_before_period(c);
    check(c == 1, "R7 direct write same cycle", c, 1);
    repeat (20) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule